// File: doc/BRIEF.md
# Vertical Sync and Field Detector

This block sits behind a sync slicer and works on its digital, active-low composite sync. A line length in clock cycles comes in from a format detector. The block measures how long each sync pulse stays low. It uses that low-time to pick out the broad pulses of the vertical interval from horizontal and equalizing pulses. From this it produces an active-low vertical sync that lasts three lines, and a field flag.

The block follows the line phase from horizontal pulses that fall one line apart. The field is then taken from where the first broad pulse falls within that phase: on a line boundary means field 1, and in the middle of a line means field 2. Some sync carries no serrations and has a single long low span for the whole vertical interval. The same low-time test starts the vertical pulse there as well. A progressive-format input forces the field flag high. A silence watchdog releases the outputs and drops the line phase.

Top module: `vsync_field_sep`

## Requirements
- R1: A low span longer than line_len/4 clock cycles is a broad pulse. vsync_n falls on the rising edge that comes line_len/4 + 1 edges after the edge that first samples the low input.
- R2: Each vsync_n low pulse lasts exactly 3*line_len clock cycles. Broad pulses that arrive while vsync_n is low start no new pulse, so one vertical interval gives one pulse.
- R3: A single unbroken low span longer than one line, with no serrations, gives exactly one vsync_n pulse of 3*line_len cycles.
- R4: The line phase is set by a pulse with low-time of at most line_len/4 whose falling edge lies line_len ± line_len/8 cycles after the previous falling edge. A broad pulse whose falling edge lies within ±line_len/8 of a whole number of lines from that reference sets field 1 (field_odd = 1).
- R5: A broad pulse that falls within ±line_len/8 of half a line past the reference sets field 2 (field_odd = 0). Any other position leaves the field unchanged. Equalizing pulses spaced half a line apart do not move the reference.
- R6: While progressive is stable, field_odd changes only in the cycle in which vsync_n falls.
- R7: While progressive is 1, field_odd is 1.
- R8: While the sync input stays high, vsync_n stays high and field_odd keeps its value.
- R9: After 4*line_len cycles with no sync edge, vsync_n is released and the line phase is forgotten. The next broad pulse then pulses vsync_n but leaves field_odd unchanged.
- R10: After reset, vsync_n is 1 and field_odd is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csync_n | input | 1 | Sliced composite sync, active low |
| line_len | input | LW | Line period in clock cycles |
| progressive | input | 1 | 1 when the format is progressive |
| vsync_n | output | 1 | Vertical sync, active low |
| field_odd | output | 1 | 1 in field 1, 0 in field 2 |

## Verification
Each rising edge registers the input once. The vertical pulse and the field update therefore appear line_len/4 + 1 edges after the first low sample of a broad pulse, and the bench probes the cycles on both sides of that point. A behavioural model counts input samples and fall times. It reproduces that latency and the 3*line_len width, and it is compared with both outputs at every falling clock edge, away from the edge where they change. Checks for pulse width, pulse count and field value are placed after each scenario, once the three-line pulse is known to have ended.

// File: rtl/vsync_field_sep.sv
module vsync_field_sep #(
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csync_n,
  input  logic [LW-1:0] line_len,
  input  logic          progressive,
  output logic          vsync_n,
  output logic          field_odd
);
  localparam int CW = LW + 3;
  localparam logic [CW-1:0] SMAX = {1'b0, {(CW-1){1'b1}}};

  logic [CW-1:0] len, qtr, half, eighth, vlen, wdlim;
  assign len    = CW'(line_len);
  assign qtr    = len >> 2;
  assign half   = len >> 1;
  assign eighth = len >> 3;
  assign vlen   = len + (len << 1);
  assign wdlim  = len << 2;

  logic s_q, s_p;
  logic [CW-1:0] lo_cnt, sf, gap, vcnt, ph, fall_ph, sp;
  logic full_q, locked, odd_q;

  wire fall   = s_p & ~s_q;
  wire rise   = ~s_p & s_q;
  wire wd     = gap >= wdlim;
  wire hit    = ~s_q && (lo_cnt == qtr) && (vcnt == '0) && !wd;
  wire resync = rise && (lo_cnt <= qtr) && full_q;
  assign sp = sf + CW'(1);
  wire near_full = (sp >= len - eighth) && (sp <= len + eighth);
  wire pos_full  = (fall_ph <= eighth) || (fall_ph >= len - eighth);
  wire pos_half  = (fall_ph >= half - eighth) && (fall_ph <= half + eighth);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= 1'b1;
      s_p <= 1'b1;
      lo_cnt <= '0;
      sf <= SMAX;
      gap <= '0;
    end else begin
      s_q <= csync_n;
      s_p <= s_q;
      lo_cnt <= s_q ? '0 : (lo_cnt == SMAX ? lo_cnt : lo_cnt + CW'(1));
      sf <= fall ? '0 : (sf == SMAX ? sf : sp);
      gap <= (fall || rise) ? '0 : (gap == SMAX ? gap : gap + CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ph <= '0;
      fall_ph <= '0;
      locked <= 1'b0;
    end else begin
      if (fall) begin
        full_q <= near_full;
        fall_ph <= ph;
      end
      if (resync) ph <= lo_cnt + CW'(1);
      else ph <= (ph >= len - CW'(1)) ? '0 : ph + CW'(1);
      if (wd) locked <= 1'b0;
      else if (resync) locked <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt <= '0;
      odd_q <= 1'b1;
    end else begin
      if (wd) vcnt <= '0;
      else if (hit) vcnt <= vlen;
      else if (vcnt != '0) vcnt <= vcnt - CW'(1);
      if (hit && locked) begin
        if (pos_full) odd_q <= 1'b1;
        else if (pos_half) odd_q <= 1'b0;
      end
    end
  end

  assign vsync_n   = (vcnt == '0);
  assign field_odd = progressive | odd_q;

  logic [CW-1:0] vs_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vs_len <= '0;
    else vs_len <= vsync_n ? '0 : vs_len + CW'(1);
  end

  a_r1_low_input: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_n) |-> $past(!s_q));
  a_r2_width_cap: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> vs_len < vlen);
  a_r6_field_at_vfall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(odd_q) |-> (!vsync_n && $past(vsync_n)));
  a_r7_prog_high: assert property (@(posedge clk) disable iff (!rst_n)
    progressive |-> field_odd);
  a_r9_wd_release: assert property (@(posedge clk) disable iff (!rst_n)
    wd |=> vsync_n);
endmodule

// File: tb/tb_vsync_field_sep.sv
module tb_vsync_field_sep;
  localparam int L = 64;
  localparam int Q = L / 4;
  localparam int E = L / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csync_n = 1'b1;
  logic progressive = 1'b0;
  logic vsync_n, field_odd;

  vsync_field_sep #(.LW(12)) dut (
    .clk(clk), .rst_n(rst_n), .csync_n(csync_n), .line_len(12'(L)),
    .progressive(progressive), .vsync_n(vsync_n), .field_odd(field_odd));

  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  string cur_req = "R10";

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, got, exp, $time);
    end
  endtask

  // behavioural reference model
  int t, run, gap, vc, last_fall, cur_fall, ref_t, d;
  bit prev, prev2, cur_full, lk, m_odd, wdf;
  always @(posedge clk) begin
    if (!rst_n) begin
      t = 0; run = 0; gap = 0; vc = 0; last_fall = -1000000; cur_fall = 0; ref_t = 0;
      prev = 1; prev2 = 1; cur_full = 0; lk = 0; m_odd = 1;
    end else begin
      wdf = gap >= 4 * L;
      if (prev != prev2) gap = 0; else gap++;
      if (!prev && prev2) begin
        cur_full = ((t - 1 - last_fall) >= L - E) && ((t - 1 - last_fall) <= L + E);
        last_fall = t - 1;
        cur_fall = t - 1;
      end
      if (prev && !prev2 && run <= Q && cur_full) begin
        ref_t = cur_fall;
        lk = 1;
      end
      run = prev ? 0 : run + 1;
      if (wdf) begin
        vc = 0; lk = 0;
      end else if (!prev && run == Q + 1 && vc == 0) begin
        vc = 3 * L;
        if (lk) begin
          d = (cur_fall - ref_t) % L;
          if (d <= E || d >= L - E) m_odd = 1;
          else if (d >= L / 2 - E && d <= L / 2 + E) m_odd = 0;
        end
      end else if (vc > 0) vc--;
      prev2 = prev;
      prev = csync_n;
      t++;
    end
  end

  // per-cycle comparison and independent monitors
  int vs_falls = 0, cur_w = 0, last_w = 0;
  bit last_vs = 1, last_fld = 1, last_prog = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk({cur_req, " vsync_n vs model"}, vsync_n, (vc == 0));
      chk({cur_req, " field_odd vs model"}, field_odd, (progressive | m_odd));
      if (last_vs && !vsync_n) begin vs_falls++; cur_w = 0; end
      if (!vsync_n) cur_w++;
      if (!last_vs && vsync_n) last_w = cur_w;
      if (field_odd != last_fld && progressive == last_prog)
        chk("R6 field change at vsync fall", (last_vs && !vsync_n), 1);
      last_vs = vsync_n; last_fld = field_odd; last_prog = progressive;
    end
  end

  task automatic seg(input bit v, input int n);
    csync_n = v;
    repeat (n) @(negedge clk);
  endtask
  task automatic hlines(input int n);
    for (int i = 0; i < n; i++) begin seg(0, 5); seg(1, L - 5); end
  endtask
  task automatic broad6(input bit probe);
    csync_n = 0;
    for (int k = 1; k <= 26; k++) begin
      @(negedge clk);
      if (probe && k == Q + 1) chk("R1 vsync still high before trigger", vsync_n, 1);
      if (probe && k == Q + 2) chk("R1 vsync low at trigger", vsync_n, 0);
    end
    seg(1, 6);
    for (int i = 0; i < 5; i++) begin seg(0, 26); seg(1, 6); end
  endtask
  task automatic interval_done(input string req, input int falls0, input int fld);
    chk({req, " one vsync pulse"}, vs_falls - falls0, 1);
    chk({req, " vsync width"}, last_w, 3 * L);
    chk({req, " field"}, field_odd, fld);
  endtask

  int f0;
  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset vsync_n", vsync_n, 1);
    chk("R10 reset field_odd", field_odd, 1);

    cur_req = "R1/R4"; f0 = vs_falls;
    hlines(8); broad6(1); hlines(8);
    interval_done("R2 R4 odd", f0, 1);

    cur_req = "R5"; f0 = vs_falls;
    hlines(7); seg(0, 5); seg(1, L / 2 - 5); broad6(0); hlines(8);
    interval_done("R5 even", f0, 0);

    cur_req = "R5 off"; f0 = vs_falls;
    hlines(7); seg(0, 5); seg(1, L / 4 - 5); broad6(0); hlines(8);
    interval_done("R5 off-position keeps", f0, 0);

    cur_req = "R4"; f0 = vs_falls;
    hlines(8); broad6(0); hlines(8);
    interval_done("R4 odd again", f0, 1);

    cur_req = "R5 eq"; f0 = vs_falls;
    hlines(8);
    for (int i = 0; i < 3; i++) begin seg(0, 2); seg(1, L / 2 - 2); end
    broad6(0); hlines(8);
    interval_done("R5 equalizing even", f0, 0);

    cur_req = "R3"; f0 = vs_falls;
    hlines(8); seg(0, 2 * L); hlines(8);
    interval_done("R3 no serration", f0, 1);

    cur_req = "R8/R9"; f0 = vs_falls;
    hlines(4); seg(1, 4 * L + L / 2);
    chk("R8 idle vsync high", vsync_n, 1);
    chk("R8 idle field held", field_odd, 1);
    chk("R8 no pulse while idle", vs_falls - f0, 0);
    broad6(0); hlines(8);
    interval_done("R9 phase lost keeps field", f0, 1);

    cur_req = "R7"; f0 = vs_falls;
    hlines(8);
    progressive = 1;
    hlines(7); seg(0, 5); seg(1, L / 2 - 5); broad6(0); hlines(8);
    interval_done("R7 progressive", f0, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule